// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block turns a set of level-sensitive interrupt sources into a single interrupt request for a processor. It also hands the processor the address of the handler to run. Sixteen vector slots, each bound by software to one source, form a fixed priority ladder: slot 0 is the most urgent and slot 15 the least. A default vector catches anything that no enabled slot claims. Source masking and the fast-interrupt path sit upstream. The block receives two vectors: the raw pending sources, and the pending sources already gated down to the normal request path.

The controller keeps a nesting priority level. When the handler reads the active-vector word, the level drops to the most urgent pending slot that is above the one currently in service. The old level is saved, and the block returns that slot's address. When the handler writes the active-vector word, the saved level comes back. The request line is raised only for gated sources that belong to a slot more urgent than the current level, so a handler can be pre-empted only by higher-priority work.

The register port carries word addresses, with the byte offset equal to four times the word address. It also has level read and write strobes. An access happens on the first cycle a strobe is seen high, and read data appears on the clock after that.

Top module: `vec_prio_intc`

## Requirements
- R1: After reset, all vector addresses, all control bytes and the default vector are zero. The level is idle, and `irqOut` is low.
- R2: Vector address slot n is at word 0x40+n and control slot n at word 0x80+n. The default vector is at word 13. These hold what was written, with only the low 8 bits kept for control. Any unmapped word reads zero.
- R3: In a control byte, bit 5 enables the slot and bits 4:0 pick its source. `irqOut` is high one clock after `pendGated` has a bit that is served by an enabled slot more urgent than the current level. While idle, any bit counts.
- R4: `irqOut` is low one clock after `pendGated` is all zero.
- R5: A read of the active-vector word (word 12) finds the most urgent enabled slot whose source is set in `pendRaw` and that is more urgent than the current level. It saves the current level, moves to that slot and returns its address. When the level is idle and only unclaimed sources are pending, it moves to the default level and returns the default vector.
- R6: A read of the active-vector word that finds no qualifying slot leaves the level unchanged. It returns the address of the current level, or the default vector when idle.
- R7: A read or write strobe held high for several cycles counts as one access.
- R8: A write to the active-vector word ignores its data and restores the level saved when the current one was entered. At idle it has no effect.
- R9: Levels nest: a more urgent slot pre-empts a running one, and its write returns the block to the pre-empted slot.
- R10: A write to a control slot changes the priority masks that are used from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pendRaw | input | 32 | Raw pending sources, used by the vector search |
| pendGated | input | 32 | Enabled, normal-path pending sources, used for the request |
| busRd | input | 1 | Read strobe (level; first high cycle is the access) |
| busWr | input | 1 | Write strobe (level; first high cycle is the access) |
| busAddr | input | 10 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid from the clock after the access |
| irqOut | output | 1 | Registered interrupt request |

## Verification
On every cycle the assertions check the following. A held strobe never produces a second access. A successful push always makes the level more urgent. A pop at idle leaves the level idle. The request follows the all-zero and idle cases one clock later. Which address comes back, how nested levels unwind, and how control writes reshape the masks depend on the programmed slot layout. Only the bench's sweeps show these: they run over every slot, through pre-emption chains, held strobes and slot reprogramming.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int SLOT_W = 4;
  localparam int CTL_EN_BIT = 5;

  typedef enum logic [2:0] {
    RK_NONE, RK_VEC, RK_CTL, RK_ACT, RK_DEF
  } rd_kind_e;

  typedef struct packed {
    logic             rdEn;
    rd_kind_e         rdKind;
    logic             push;
    logic             pop;
    logic             wrVec;
    logic             wrCtl;
    logic             wrDef;
    logic [SLOT_W-1:0] slot;
  } vic_strb_t;
endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output vic_strb_t         strb
);
  localparam int BLK_W = ADDR_W - SLOT_W;
  localparam logic [BLK_W-1:0]  VEC_BLK  = BLK_W'(4);
  localparam logic [BLK_W-1:0]  CTL_BLK  = BLK_W'(8);
  localparam logic [ADDR_W-1:0] ACT_WORD = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] DEF_WORD = ADDR_W'(13);

  logic prevRd, prevWr;
  logic rdEdge, wrEdge, inVec, inCtl, isAct, isDef;

  // Strobes held through reset stay ignored until seen low once.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevRd <= 1'b1;
      prevWr <= 1'b1;
    end else begin
      prevRd <= busRd;
      prevWr <= busWr;
    end
  end

  always_comb begin
    rdEdge = busRd & ~prevRd;
    wrEdge = busWr & ~prevWr;
    inVec  = busAddr[ADDR_W-1:SLOT_W] == VEC_BLK;
    inCtl  = busAddr[ADDR_W-1:SLOT_W] == CTL_BLK;
    isAct  = busAddr == ACT_WORD;
    isDef  = busAddr == DEF_WORD;

    strb.rdEn  = rdEdge;
    strb.push  = rdEdge & isAct;
    strb.pop   = wrEdge & isAct;
    strb.wrVec = wrEdge & inVec;
    strb.wrCtl = wrEdge & inCtl;
    strb.wrDef = wrEdge & isDef;
    strb.slot  = busAddr[SLOT_W-1:0];
    if (inVec)      strb.rdKind = RK_VEC;
    else if (inCtl) strb.rdKind = RK_CTL;
    else if (isAct) strb.rdKind = RK_ACT;
    else if (isDef) strb.rdKind = RK_DEF;
    else            strb.rdKind = RK_NONE;
  end

  AST_ONE_SHOT_RD: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && $past(busRd)) |-> !strb.rdEn); // R7
  AST_ONE_SHOT_WR: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && $past(busWr)) |-> !(strb.pop || strb.wrVec || strb.wrCtl || strb.wrDef)); // R7
endmodule

// File: rtl/vic_dp.sv
module vic_dp
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_VEC = 16,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  vic_strb_t          strb,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic [NUM_SRC-1:0] pendRaw,
  input  logic [NUM_SRC-1:0] pendGated,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irqOut
);
  localparam int SEL_W  = $clog2(NUM_SRC);
  localparam int PRIO_W = $clog2(NUM_VEC + 2);
  localparam logic [PRIO_W-1:0] IDLE    = PRIO_W'(NUM_VEC + 1);
  localparam logic [PRIO_W-1:0] DEF_LVL = PRIO_W'(NUM_VEC);

  logic [DATA_W-1:0]  vecAddr  [0:NUM_VEC];
  logic [7:0]         vecCtl   [0:NUM_VEC-1];
  logic [PRIO_W-1:0]  savedLvl [0:NUM_VEC];
  logic [PRIO_W-1:0]  prio;
  logic [NUM_SRC-1:0] prioMask [0:NUM_VEC+1];
  logic [NUM_SRC-1:0] slotBits [0:NUM_VEC-1];

  // Mask of level i: sources of all enabled slots more urgent than i.
  assign prioMask[0]         = '0;
  assign prioMask[NUM_VEC+1] = '1;
  for (genvar i = 0; i < NUM_VEC; i++) begin : g_mask
    assign slotBits[i] = vecCtl[i][CTL_EN_BIT]
                       ? (NUM_SRC'(1) << vecCtl[i][SEL_W-1:0]) : '0;
    assign prioMask[i+1] = prioMask[i] | slotBits[i];
  end

  logic              hitFound;
  logic [PRIO_W-1:0] hitIdx, nextLvl, actIdx;

  always_comb begin
    hitFound = 1'b0;
    hitIdx   = IDLE;
    for (int i = 0; i <= NUM_VEC; i++) begin
      if (!hitFound && (PRIO_W'(i) < prio) && (|(pendRaw & prioMask[i+1]))) begin
        hitFound = 1'b1;
        hitIdx   = PRIO_W'(i);
      end
    end
    nextLvl = hitFound ? hitIdx : prio;
    actIdx  = (nextLvl == IDLE) ? DEF_LVL : nextLvl;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k <= NUM_VEC; k++) begin
        vecAddr[k]  <= '0;
        savedLvl[k] <= IDLE;
      end
      for (int k = 0; k < NUM_VEC; k++) vecCtl[k] <= '0;
      prio     <= IDLE;
      busRdata <= '0;
      irqOut   <= 1'b0;
    end else begin
      irqOut <= |(pendGated & prioMask[prio]);
      if (strb.wrVec) vecAddr[PRIO_W'(strb.slot)] <= busWdata;
      if (strb.wrDef) vecAddr[DEF_LVL] <= busWdata;
      if (strb.wrCtl) vecCtl[strb.slot] <= busWdata[7:0];
      if (strb.push && hitFound) begin
        savedLvl[hitIdx] <= prio;
        prio             <= hitIdx;
      end else if (strb.pop && prio != IDLE) begin
        prio <= savedLvl[prio];
      end
      if (strb.rdEn) begin
        case (strb.rdKind)
          RK_VEC:  busRdata <= vecAddr[PRIO_W'(strb.slot)];
          RK_CTL:  busRdata <= DATA_W'(vecCtl[strb.slot]);
          RK_ACT:  busRdata <= vecAddr[actIdx];
          RK_DEF:  busRdata <= vecAddr[DEF_LVL];
          default: busRdata <= '0;
        endcase
      end
    end
  end

  AST_PUSH_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && hitFound) |=> (prio < $past(prio))); // R5
  AST_IDLE_POP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && prio == IDLE && !strb.push) |=> (prio == IDLE)); // R8
  AST_NO_PEND_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (pendGated == '0) |=> !irqOut); // R4
  AST_IDLE_ANY_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (prio == IDLE && pendGated != '0) |=> irqOut); // R3
endmodule

// File: rtl/vec_prio_intc.sv
module vec_prio_intc
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_VEC = 16,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pendRaw,
  input  logic [NUM_SRC-1:0] pendGated,
  input  logic               busRd,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irqOut
);
  vic_strb_t strb;

  vic_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busRd(busRd), .busWr(busWr),
    .busAddr(busAddr), .strb(strb)
  );

  vic_dp #(.NUM_SRC(NUM_SRC), .NUM_VEC(NUM_VEC), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .pendRaw(pendRaw), .pendGated(pendGated),
    .busRdata(busRdata), .irqOut(irqOut)
  );
endmodule

// File: tb/sim_vec_prio_intc.sv
`timescale 1ns/1ps
module sim_vec_prio_intc;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] pendRaw = '0, pendGated = '0;
  logic        busRd = 1'b0, busWr = 1'b0;
  logic [9:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  vec_prio_intc u0 (
    .clk(clk), .rstN(rstN), .pendRaw(pendRaw), .pendGated(pendGated),
    .busRd(busRd), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut)
  );

  always #4 clk = ~clk;

  localparam logic [9:0] W_ACT = 10'd12, W_DEF = 10'd13;
  localparam logic [31:0] DEF_VEC = 32'hDEF0_0000;

  function automatic int srcOf(int n); return (n * 5 + 3) % 32; endfunction
  function automatic logic [31:0] addrOf(int n); return 32'hA000_0000 + 32'(n) * 32'h44; endfunction
  function automatic logic [31:0] bitOf(int s); return 32'h1 << s; endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic busRead(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busRd = 1'b1;
    @(negedge clk); d = busRdata; busRd = 1'b0;
  endtask

  task automatic setPend(input logic [31:0] p);
    @(negedge clk); pendRaw = p; pendGated = p;
  endtask

  task automatic settle; repeat (2) @(negedge clk); endtask

  task automatic chkIrq(input logic exp, input string req);
    settle();
    chk(irqOut === exp, req, {31'b0, irqOut}, {31'b0, exp});
  endtask

  task automatic chkRead(input logic [9:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    busRead(a, d);
    chk(d === exp, req, d, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(irqOut === 1'b0, "R1 irq", {31'b0, irqOut}, 32'd0);
    chkRead(10'h043, 32'd0, "R1 vec slot");
    chkRead(10'h083, 32'd0, "R1 ctl slot");
    chkRead(W_DEF, 32'd0, "R1 default");
    chkRead(W_ACT, 32'd0, "R1 R6 act idle empty");

    // R2: program and read back every slot
    for (int n = 0; n < 16; n++) begin
      busWrite(10'h040 + 10'(n), addrOf(n));
      busWrite(10'h080 + 10'(n), 32'hFFFF_FF20 | 32'(srcOf(n)));
    end
    busWrite(W_DEF, DEF_VEC);
    for (int n = 0; n < 16; n++) begin
      chkRead(10'h040 + 10'(n), addrOf(n), "R2 vec readback");
      chkRead(10'h080 + 10'(n), 32'h20 | 32'(srcOf(n)), "R2 ctl readback");
    end
    chkRead(W_DEF, DEF_VEC, "R2 default readback");
    chkRead(10'h003, 32'd0, "R2 unmapped");

    // R3/R4 at idle
    setPend(bitOf(srcOf(7)));
    chkIrq(1'b1, "R3 idle pending");
    setPend(32'd0);
    chkIrq(1'b0, "R4 nothing pending");

    // R5 sweep over every slot
    for (int n = 0; n < 16; n++) begin
      setPend(bitOf(srcOf(n)));
      chkRead(W_ACT, addrOf(n), "R5 active vector");
      chkIrq(1'b0, "R3 own source masked");
      if (n > 0) begin
        setPend(bitOf(srcOf(n)) | bitOf(srcOf(0)));
        chkIrq(1'b1, "R3 more urgent source");
        setPend(bitOf(srcOf(n)));
      end
      busWrite(W_ACT, 32'hFFFF_FFFF);
      chkIrq(1'b1, "R8 pop to idle");
    end

    // R6 / R8 at idle
    setPend(32'd0);
    chkRead(W_ACT, DEF_VEC, "R6 idle no pending");
    busWrite(W_ACT, 32'h0);
    setPend(bitOf(srcOf(15)));
    chkRead(W_ACT, addrOf(15), "R8 idle pop harmless");
    busWrite(W_ACT, 32'h0);

    // R9 nesting
    setPend(bitOf(srcOf(5)));
    chkRead(W_ACT, addrOf(5), "R9 enter 5");
    setPend(bitOf(srcOf(5)) | bitOf(srcOf(2)));
    chkIrq(1'b1, "R9 preempt request");
    chkRead(W_ACT, addrOf(2), "R9 enter 2");
    chkRead(W_ACT, addrOf(2), "R6 no higher at 2");
    setPend(bitOf(srcOf(5)));
    busWrite(W_ACT, 32'h0);
    chkRead(W_ACT, addrOf(5), "R9 back to 5");
    chkIrq(1'b0, "R9 level 5 masks own");
    busWrite(W_ACT, 32'h0);
    chkIrq(1'b1, "R9 back to idle");

    // R5 default level for an unclaimed source (source 0)
    setPend(32'h1);
    chkRead(W_ACT, DEF_VEC, "R5 default level");
    chkIrq(1'b0, "R5 default masks unclaimed");
    busWrite(W_ACT, 32'h0);
    chkIrq(1'b1, "R8 pop default");

    // R7 held read strobe
    setPend(bitOf(srcOf(9)));
    @(negedge clk); busAddr = W_ACT; busRd = 1'b1;
    @(negedge clk);
    chk(busRdata === addrOf(9), "R7 first access", busRdata, addrOf(9));
    pendRaw = bitOf(srcOf(9)) | bitOf(srcOf(3)); pendGated = pendRaw;
    repeat (3) @(negedge clk);
    chk(busRdata === addrOf(9), "R7 held read data", busRdata, addrOf(9));
    busRd = 1'b0;
    setPend(32'd0);
    busWrite(W_ACT, 32'h0);
    setPend(bitOf(srcOf(9)));
    chkIrq(1'b1, "R7 single push");

    // R7 held write strobe: one pop only
    setPend(bitOf(srcOf(6)));
    chkRead(W_ACT, addrOf(6), "R7 enter 6");
    setPend(bitOf(srcOf(6)) | bitOf(srcOf(1)));
    chkRead(W_ACT, addrOf(1), "R7 enter 1");
    @(negedge clk); busAddr = W_ACT; busWr = 1'b1;
    repeat (4) @(negedge clk); busWr = 1'b0;
    setPend(bitOf(srcOf(6)));
    chkIrq(1'b0, "R7 held write one pop");
    busWrite(W_ACT, 32'h0);

    // R10 control rewrite changes masks
    setPend(bitOf(srcOf(15)));
    chkRead(W_ACT, addrOf(15), "R10 enter 15");
    setPend(32'h1);
    chkIrq(1'b0, "R10 before rewrite");
    busWrite(10'h080 + 10'd14, 32'h20);
    chkIrq(1'b1, "R10 after rewrite");
    busWrite(W_ACT, 32'h0);
    busWrite(10'h080 + 10'd2, 32'(srcOf(2)));
    @(negedge clk); pendRaw = bitOf(srcOf(2)); pendGated = '0;
    chkRead(W_ACT, DEF_VEC, "R10 disabled slot");
    busWrite(W_ACT, 32'h0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule